// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block keeps the output latch of one general-purpose I/O port and turns it, pin by pin, into the enable signals of a quasi-bidirectional pad. Each pin has four drive controls: a pull-down, a very-weak pull-up, a weak pull-up and a strong pull-up. A pin whose latch bit is 0 pulls low. A pin whose latch bit is 1 keeps the very-weak pull-up on, and it keeps the weak pull-up on only while the pad reads back high. On a 0-to-1 change of its latch bit, a pin also gets one clock of the strong pull-up so that the rising edge is fast.

The sampled pad levels pass through one register stage. That registered value is what the CPU reads on the port, and the weak pull-up logic uses the same value. A power-down input freezes this input register on every pin except the designated wake pins. Any pin can be put in input-only mode, which switches off all four drive controls. A second read port returns the latch contents for read-modify-write use.

The write port is a plain strobe. It has no back-pressure and is accepted on every clock it is high. Pad samples are taken on every clock and are never stalled.

Top module: `qb_port_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `latch_q` is all ones and `port_rd` is all ones. With `in_only` at zero, every pin shows very-weak and weak pull-ups on, and the pull-down and strong pull-up off.
- R2: A clock edge with `wr_en` high loads `wr_data` into the latch, and `latch_q` shows it from that edge on. A clock edge with `wr_en` low leaves the latch unchanged.
- R3: A pin whose latch bit is 0 and whose `in_only` bit is 0 has `pull_dn_en` at 1 and all three pull-up enables at 0.
- R4: A pin whose latch bit is 1 and whose `in_only` bit is 0 has `vweak_pu_en` at 1, whatever its pad level.
- R5: `weak_pu_en` of a pin is 1 exactly when its latch bit is 1, its registered pad bit is 1 and its `in_only` bit is 0. A pad pulled low therefore turns the weak pull-up off one clock later.
- R6: When a write changes a latch bit from 0 to 1, that pin's `strong_pu_en` is 1 for exactly the one cycle that follows the write edge, provided its `in_only` bit is 0.
- R7: A write that stores 1 into a latch bit that already holds 1 produces no strong pull-up pulse on that pin.
- R8: While `pwr_down` is 0, `port_rd` equals `pad_in` as sampled at the previous clock edge.
- R9: While `pwr_down` is 1, the `port_rd` bits outside `WAKE_MASK` hold their value, and the bits inside `WAKE_MASK` go on following `pad_in` with one clock of delay. The default `WAKE_MASK` is bits 2 and 3.
- R10: A pin whose `in_only` bit is 1 has all four drive enables at 0. Its latch and its `port_rd` bit keep working as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | WIDTH | Value written to the latch |
| pwr_down | input | 1 | Power-down; freezes the input register on pins outside the wake mask |
| pad_in | input | WIDTH | Raw pad levels |
| in_only | input | WIDTH | Per-pin input-only mode select |
| latch_q | output | WIDTH | Latch contents, for read-modify-write |
| port_rd | output | WIDTH | Registered pad value read by the CPU |
| pull_dn_en | output | WIDTH | Pull-down enable per pin |
| vweak_pu_en | output | WIDTH | Very-weak pull-up enable per pin |
| weak_pu_en | output | WIDTH | Weak pull-up enable per pin |
| strong_pu_en | output | WIDTH | One-clock strong pull-up pulse per pin |

## Verification
A write shows up in `latch_q`, `pull_dn_en` and `vweak_pu_en` right after the write edge. The strong pulse is high for exactly that one cycle. A change on `pad_in` reaches `port_rd` and `weak_pu_en` one edge later. `in_only` acts combinationally on the drive enables. The bench applies each stimulus on the falling edge and lets one rising edge pass. A model applies the same edge to its own latch and input register. The bench then compares every output on the next falling edge. Directed steps show that a second write of 1 produces no pulse, and that the pulse is gone by the following cycle.

// File: rtl/qb_pkg.sv
package qb_pkg;

  // Drive enables for one quasi-bidirectional pad.
  typedef struct packed {
    logic pull_dn;
    logic pu_vweak;
    logic pu_weak;
    logic pu_strong;
  } pin_drive_t;

  localparam pin_drive_t DRIVE_OFF = '{pull_dn: 1'b0, pu_vweak: 1'b0,
                                       pu_weak: 1'b0, pu_strong: 1'b0};

  // Decode of one pin from its latch bit, registered pad level and edge flag.
  function automatic pin_drive_t decode_pin(input logic latch_bit,
                                            input logic pad_bit,
                                            input logic rise_bit,
                                            input logic in_only_bit);
    pin_drive_t d;
    d = DRIVE_OFF;
    if (!in_only_bit) begin
      d.pull_dn   = ~latch_bit;
      d.pu_vweak  = latch_bit;
      d.pu_weak   = latch_bit & pad_bit;
      d.pu_strong = latch_bit & rise_bit;
    end
    return d;
  endfunction

endpackage

// File: rtl/qb_latch.sv
module qb_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] rise_q
);

  localparam logic [WIDTH-1:0] LATCH_RST = '1;

  logic [WIDTH-1:0] rise_d;

  // A bit rises only when it is stored as 1 while currently 0.
  assign rise_d = wr_en ? (wr_data & ~latch_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= LATCH_RST;
      rise_q  <= '0;
    end else begin
      if (wr_en) latch_q <= wr_data;
      rise_q <= rise_d;
    end
  end

  assert_latch_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_en) |-> latch_q == $past(wr_data));

  assert_latch_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(wr_en) |-> $stable(latch_q));

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise_q[i] |=> !rise_q[i]);
    assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && rise_q[i] |-> latch_q[i] && !$past(latch_q[i]));
  end

endmodule

// File: rtl/qb_in_sync.sv
module qb_in_sync #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] WAKE_MASK = WIDTH'(12)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_q
);

  localparam logic PAD_RST = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic samp_en;
    if (WAKE_MASK[i]) begin : g_wake
      assign samp_en = 1'b1;
    end else begin : g_gated
      assign samp_en = ~pwr_down;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       pad_q[i] <= PAD_RST;
      else if (samp_en) pad_q[i] <= pad_in[i];
    end

    if (WAKE_MASK[i]) begin : g_chk_wake
      assert_wake_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pad_q[i] == $past(pad_in[i]));
    end else begin : g_chk_gated
      assert_gated_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(pwr_down) |-> $stable(pad_q[i]));
      assert_gated_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(pwr_down) |-> pad_q[i] == $past(pad_in[i]));
    end
  end

endmodule

// File: rtl/qb_drive.sv
module qb_drive
  import qb_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] pad_q,
  input  logic [WIDTH-1:0] rise_q,
  input  logic [WIDTH-1:0] in_only,
  output pin_drive_t       drv [WIDTH]
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb drv[i] = decode_pin(latch_q[i], pad_q[i], rise_q[i], in_only[i]);

    assert_low_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      drv[i].pull_dn |-> !(drv[i].pu_vweak || drv[i].pu_weak || drv[i].pu_strong));
    assert_weak_implies_vweak_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drv[i].pu_weak |-> drv[i].pu_vweak && pad_q[i]);
    assert_hiz_input_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_only[i] |-> $countones({drv[i].pull_dn, drv[i].pu_vweak,
                                 drv[i].pu_weak, drv[i].pu_strong}) == 0);
    assert_driven_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_only[i] |-> $onehot({drv[i].pull_dn, drv[i].pu_vweak}));
  end

endmodule

// File: rtl/qb_port_ctrl.sv
module qb_port_ctrl
  import qb_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] WAKE_MASK = WIDTH'(12)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pwr_down,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] in_only,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] port_rd,
  output logic [WIDTH-1:0] pull_dn_en,
  output logic [WIDTH-1:0] vweak_pu_en,
  output logic [WIDTH-1:0] weak_pu_en,
  output logic [WIDTH-1:0] strong_pu_en
);

  logic [WIDTH-1:0] rise_q;
  logic [WIDTH-1:0] pad_q;
  pin_drive_t       drv [WIDTH];

  qb_latch #(.WIDTH(WIDTH)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .latch_q (latch_q),
    .rise_q  (rise_q)
  );

  qb_in_sync #(.WIDTH(WIDTH), .WAKE_MASK(WAKE_MASK)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_down (pwr_down),
    .pad_in   (pad_in),
    .pad_q    (pad_q)
  );

  qb_drive #(.WIDTH(WIDTH)) u_drive (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch_q (latch_q),
    .pad_q   (pad_q),
    .rise_q  (rise_q),
    .in_only (in_only),
    .drv     (drv)
  );

  assign port_rd = pad_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign pull_dn_en[i]   = drv[i].pull_dn;
    assign vweak_pu_en[i]  = drv[i].pu_vweak;
    assign weak_pu_en[i]   = drv[i].pu_weak;
    assign strong_pu_en[i] = drv[i].pu_strong;
  end

  assert_strong_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (strong_pu_en & ~($past(wr_en) ? $past(wr_data) : '0)) == '0);

endmodule

// File: tb/qb_port_ctrl_tb.sv
`timescale 1ns/1ps
module qb_port_ctrl_tb;

  localparam int         W    = 8;
  localparam logic [7:0] WAKE = 8'h0C;
  localparam int         NV   = 12;

  // Stimulus row layout: {wr_en, wr_data, pad_in, in_only, pwr_down}.
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'hFF, 8'h00, 1'b0},
    {1'b1, 8'h0F, 8'hFF, 8'h00, 1'b0},
    {1'b1, 8'hFF, 8'hFF, 8'h00, 1'b0},
    {1'b0, 8'h00, 8'hF0, 8'h00, 1'b0},
    {1'b1, 8'hFF, 8'hF0, 8'h00, 1'b0},
    {1'b0, 8'h00, 8'hAA, 8'h0F, 1'b0},
    {1'b1, 8'h55, 8'hAA, 8'hF0, 1'b0},
    {1'b1, 8'hFF, 8'h33, 8'h00, 1'b1},
    {1'b0, 8'h00, 8'hCC, 8'h00, 1'b1},
    {1'b0, 8'h00, 8'hCC, 8'h00, 1'b0},
    {1'b1, 8'h3C, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'hC3, 8'hFF, 8'hFF, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, pwr_down;
  logic [W-1:0] wr_data, pad_in, in_only;
  logic [W-1:0] latch_q, port_rd, pull_dn_en, vweak_pu_en, weak_pu_en, strong_pu_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] m_latch, m_pad, m_rise;

  always #4 clk = ~clk;

  qb_port_ctrl #(.WIDTH(W), .WAKE_MASK(WAKE)) u_dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .pwr_down (pwr_down), .pad_in (pad_in), .in_only (in_only),
    .latch_q (latch_q), .port_rd (port_rd), .pull_dn_en (pull_dn_en),
    .vweak_pu_en (vweak_pu_en), .weak_pu_en (weak_pu_en),
    .strong_pu_en (strong_pu_en)
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One rising edge for both the DUT and the model, then compare at the falling edge.
  task automatic step();
    m_rise = wr_en ? (wr_data & ~m_latch) : '0;
    if (wr_en) m_latch = wr_data;
    m_pad = pwr_down ? ((m_pad & ~WAKE) | (pad_in & WAKE)) : pad_in;
    @(negedge clk);
  endtask

  task automatic check_all();
    check("R2", "latch_q", latch_q, m_latch);
    check(pwr_down ? "R9" : "R8", "port_rd", port_rd, m_pad);
    check("R3", "pull_dn_en", pull_dn_en, ~m_latch & ~in_only);
    check("R4", "vweak_pu_en", vweak_pu_en, m_latch & ~in_only);
    check("R5", "weak_pu_en", weak_pu_en, m_latch & m_pad & ~in_only);
    check("R6", "strong_pu_en", strong_pu_en, m_rise & ~in_only);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; pwr_down = 1'b0;
    pad_in = 8'h00; in_only = '0;
    m_latch = '1; m_pad = '1; m_rise = '0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1", "latch_q", latch_q, 8'hFF);
    check("R1", "port_rd", port_rd, 8'hFF);
    check("R1", "weak_pu_en", weak_pu_en, 8'hFF);
    check("R1", "pull_dn_en", pull_dn_en, 8'h00);
    check("R1", "strong_pu_en", strong_pu_en, 8'h00);
    pad_in = 8'hFF;
    rst_n = 1'b1;
    @(negedge clk);
    m_pad = pad_in;
    check("R1", "vweak_pu_en", vweak_pu_en, 8'hFF);

    for (int k = 0; k < NV; k++) begin
      {wr_en, wr_data, pad_in, in_only, pwr_down} = VEC[k];
      step();
      check_all();
    end

    // R6: pulse lasts one cycle only
    wr_en = 1'b1; wr_data = 8'h00; in_only = '0; pwr_down = 1'b0; pad_in = 8'hFF;
    step();
    wr_data = 8'h81;
    step();
    check("R6", "strong_pu_en pulse", strong_pu_en, 8'h81);
    wr_en = 1'b0;
    step();
    check("R6", "strong_pu_en released", strong_pu_en, 8'h00);
    // R7: rewriting 1 over 1 gives no pulse
    wr_en = 1'b1; wr_data = 8'hFF;
    step();
    check("R7", "strong_pu_en on 1->1", strong_pu_en & 8'h81, 8'h00);
    check("R6", "strong_pu_en on 0->1", strong_pu_en, 8'h7E);
    // R10: input-only hides drive, latch still loads
    wr_data = 8'h00; in_only = 8'hFF;
    step();
    check("R10", "pull_dn_en", pull_dn_en, 8'h00);
    check("R10", "latch_q", latch_q, 8'h00);
    // R9: gated pins hold during power-down, wake pins follow
    wr_en = 1'b0; in_only = '0; pwr_down = 1'b1; pad_in = 8'h00;
    step();
    check("R9", "port_rd", port_rd, 8'hF3);
    // R5: pad low turns off weak pull-up one clock later
    pwr_down = 1'b0; wr_en = 1'b1; wr_data = 8'hFF; pad_in = 8'h0F;
    step();
    check("R5", "weak_pu_en", weak_pu_en, 8'h0F);
    check("R4", "vweak_pu_en", vweak_pu_en, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule